// File: doc/BRIEF.md
# Scatter-Gather Lane Address Unit

This block serves one SIMD subgroup that touches a flat, one-dimensional memory region through per-lane offsets. It keeps one element offset for each lane. A command can overwrite all of them, or add a separate per-lane shift to each one. A gather or scatter command then walks the lanes. It issues one memory access for each element of each enabled lane, at `base + offset + k`, where `k` runs over the lane's contiguous chunk.

Data crosses the block's data side in chunk-major order: chunk position on the outer dimension, lane on the inner one. This is the transpose of the lane-major view that the offsets describe. Gathered elements come back in that order on a wide response bus. Scatter data must be supplied in the same order, and the block captures it when the command is accepted.

A lane whose mask bit is clear produces no memory traffic, so its offset may point anywhere. Accesses are issued strictly in lane order, and in chunk order within a lane. When lanes overlap on a store, the highest lane therefore leaves the final value.

Top module: `sgl_lane_unit`

## Requirements
- R1: A command with `cmd_op` = 2'b00 (set) loads every lane's offset from `cmd_vec`, with lane `l` at bits `[l*OFF_W +: OFF_W]`. The mask is not used.
- R2: A command with `cmd_op` = 2'b10 (gather) reads element `(base + off[l] + k) mod 2^ADDR_W` for each enabled lane `l` and each chunk position `k`. It returns that element in `rsp_data[(k*LANES + l)*DATA_W +: DATA_W]`, with `rsp_valid` high in the same cycle as `cmd_done`.
- R3: `cmd_chunk` holds the chunk length minus one. The value 0 gives a single element per lane, and the value `n` gives `n+1` contiguous elements per lane.
- R4: A lane whose `cmd_mask` bit is 0 issues no memory access, even if its offset plus chunk runs past the region. On a gather, all of its chunk positions return zero.
- R5: A command with `cmd_op` = 2'b11 (scatter) writes `cmd_wdata[(k*LANES + l)*DATA_W +: DATA_W]` to address `base + off[l] + k` for each enabled lane. Memory belonging only to masked lanes is left unchanged.
- R6: When several enabled lanes of one scatter hit the same address, the value from the highest-numbered lane remains.
- R7: Accesses are issued in ascending lane order, and in ascending chunk position within each lane.
- R8: A command with `cmd_op` = 2'b01 (shift) adds `cmd_vec[l*OFF_W +: OFF_W]` to lane `l`'s offset, modulo `2^OFF_W`.
- R9: `cmd_ready` is low while a gather or scatter is in progress. `cmd_done` pulses for one cycle only after every enabled access has been acknowledged. For set and shift it pulses in the cycle after acceptance.
- R10: Once `mem_req` is raised, it stays high with `mem_addr`, `mem_we` and `mem_wdata` unchanged until a cycle with `mem_ack` high.
- R11: On a gather, chunk positions at or beyond the selected chunk length read as zero in `rsp_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command taken on valid |
| cmd_op | input | 2 | 00 set, 01 shift, 10 gather, 11 scatter |
| cmd_base | input | ADDR_W | Region base address |
| cmd_vec | input | LANES*OFF_W | Per-lane offsets (set) or shifts (shift) |
| cmd_mask | input | LANES | Per-lane enable for gather/scatter |
| cmd_chunk | input | log2(CHUNK_MAX) | Chunk length minus one |
| cmd_wdata | input | CHUNK_MAX*LANES*DATA_W | Scatter data, chunk-major |
| cmd_done | output | 1 | Command complete pulse |
| rsp_valid | output | 1 | Gather result valid pulse |
| rsp_data | output | CHUNK_MAX*LANES*DATA_W | Gather result, chunk-major |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Element address |
| mem_wdata | output | DATA_W | Write element |
| mem_ack | input | 1 | Access accepted; read data valid |
| mem_rdata | input | DATA_W | Read element |

## Verification
The assertions assume that the memory side answers only a raised request, and that it returns read data in the same cycle as `mem_ack`. The bench's memory model responds at the falling edge, acknowledging only while `mem_req` is high, with a random stall on roughly one cycle in four. Commands are offered only while `cmd_ready` is high and are dropped after one accepting edge. Offsets, masks, chunk lengths and data are drawn from a fixed-seed generator. This keeps masked lanes free to point outside the region, while every address wraps inside the modelled space.

// File: rtl/sgl_pkg.sv
package sgl_pkg;

   typedef enum logic [1:0] {
      OP_SET     = 2'b00,
      OP_SHIFT   = 2'b01,
      OP_GATHER  = 2'b10,
      OP_SCATTER = 2'b11
   } sgl_op_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } sgl_state_e;

endpackage

// File: rtl/sgl_lane_offsets.sv
module sgl_lane_offsets #(
   parameter int LANES = 16,
   parameter int OFF_W = 12
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   set_en,
   input  logic                   shift_en,
   input  logic [LANES*OFF_W-1:0] vec_in,
   output logic [LANES*OFF_W-1:0] off_flat
);

   logic [OFF_W-1:0] off_q   [LANES];
   logic [OFF_W-1:0] off_nxt [LANES];

   // per-lane next value: overwrite on set, modular add on shift
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign off_nxt[l] = set_en ? vec_in[l*OFF_W +: OFF_W]
                                 : off_q[l] + vec_in[l*OFF_W +: OFF_W];
      assign off_flat[l*OFF_W +: OFF_W] = off_q[l];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int l = 0; l < LANES; l++) off_q[l] <= '0;
      end else if (set_en || shift_en) begin
         for (int l = 0; l < LANES; l++) off_q[l] <= off_nxt[l];
      end
   end

endmodule

// File: rtl/sgl_data_buf.sv
module sgl_data_buf #(
   parameter int LANES     = 16,
   parameter int CHUNK_MAX = 8,
   parameter int DATA_W    = 32,
   localparam int LANE_W   = $clog2(LANES),
   localparam int CHK_W    = $clog2(CHUNK_MAX),
   localparam int ENTRIES  = LANES * CHUNK_MAX,
   localparam int FLAT_W   = ENTRIES * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              load,
   input  logic [FLAT_W-1:0] load_data,
   input  logic              wr_en,
   input  logic [LANE_W-1:0] wr_lane,
   input  logic [CHK_W-1:0]  wr_chk,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [LANE_W-1:0] rd_lane,
   input  logic [CHK_W-1:0]  rd_chk,
   output logic [DATA_W-1:0] rd_data,
   output logic [FLAT_W-1:0] buf_flat
);

   localparam int IDX_W = $clog2(ENTRIES);

   logic [DATA_W-1:0] ent_q [ENTRIES];
   logic [IDX_W-1:0]  widx;
   logic [IDX_W-1:0]  ridx;

   // chunk-major: entry index = chunk * LANES + lane
   assign widx = IDX_W'(wr_chk) * IDX_W'(LANES) + IDX_W'(wr_lane);
   assign ridx = IDX_W'(rd_chk) * IDX_W'(LANES) + IDX_W'(rd_lane);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         for (int e = 0; e < ENTRIES; e++) ent_q[e] <= '0;
      end else if (load) begin
         for (int e = 0; e < ENTRIES; e++) ent_q[e] <= load_data[e*DATA_W +: DATA_W];
      end else if (wr_en) begin
         ent_q[widx] <= wr_data;
      end
   end

   assign rd_data = ent_q[ridx];

   for (genvar e = 0; e < ENTRIES; e++) begin : g_flat
      assign buf_flat[e*DATA_W +: DATA_W] = ent_q[e];
   end

endmodule

// File: rtl/sgl_sequencer.sv
module sgl_sequencer
   import sgl_pkg::*;
#(
   parameter int LANES     = 16,
   parameter int CHUNK_MAX = 8,
   parameter int ADDR_W    = 12,
   parameter int OFF_W     = 12,
   localparam int LANE_W   = $clog2(LANES),
   localparam int CHK_W    = $clog2(CHUNK_MAX)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cmd_valid,
   input  logic [1:0]             cmd_op,
   input  logic [ADDR_W-1:0]      cmd_base,
   input  logic [LANES-1:0]       cmd_mask,
   input  logic [CHK_W-1:0]       cmd_chunk,
   input  logic [LANES*OFF_W-1:0] off_flat,
   output logic                   cmd_ready,
   output logic                   accept,
   output logic                   mem_req,
   output logic                   mem_we,
   output logic [ADDR_W-1:0]      mem_addr,
   input  logic                   mem_ack,
   output logic [LANE_W-1:0]      cur_lane,
   output logic [CHK_W-1:0]       cur_chk,
   output logic                   rd_wr_en,
   output logic                   cmd_done,
   output logic                   rsp_valid
);

   sgl_state_e        state_q;
   sgl_op_e           op_q;
   logic [ADDR_W-1:0] base_q;
   logic [LANES-1:0]  mask_q;
   logic [CHK_W-1:0]  chunk_q;
   logic [LANE_W-1:0] lane_q;
   logic [CHK_W-1:0]  chk_q;
   logic              done_q;
   logic              rsp_q;

   logic              running;
   logic              active;
   logic              step;
   logic              last_chk;
   logic              last_lane;
   logic [OFF_W-1:0]  off_cur;
   sgl_op_e           op_in;

   assign op_in     = sgl_op_e'(cmd_op);
   assign cmd_ready = (state_q == ST_IDLE);
   assign accept    = cmd_valid && cmd_ready;
   assign running   = (state_q == ST_RUN);
   assign active    = running && mask_q[lane_q];
   // masked lanes are passed over in one cycle without touching memory
   assign step      = running && (!mask_q[lane_q] || mem_ack);
   assign last_chk  = !mask_q[lane_q] || (chk_q == chunk_q);
   assign last_lane = (lane_q == LANE_W'(LANES - 1));
   assign off_cur   = off_flat[lane_q*OFF_W +: OFF_W];

   assign mem_req   = active;
   assign mem_we    = (op_q == OP_SCATTER);
   assign mem_addr  = base_q + ADDR_W'(off_cur) + ADDR_W'(chk_q);
   assign cur_lane  = lane_q;
   assign cur_chk   = chk_q;
   assign rd_wr_en  = active && mem_ack && (op_q == OP_GATHER);
   assign cmd_done  = done_q;
   assign rsp_valid = rsp_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         op_q    <= OP_SET;
         base_q  <= '0;
         mask_q  <= '0;
         chunk_q <= '0;
         lane_q  <= '0;
         chk_q   <= '0;
         done_q  <= 1'b0;
         rsp_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         rsp_q  <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  op_q <= op_in;
                  if (op_in == OP_GATHER || op_in == OP_SCATTER) begin
                     base_q  <= cmd_base;
                     mask_q  <= cmd_mask;
                     chunk_q <= cmd_chunk;
                     lane_q  <= '0;
                     chk_q   <= '0;
                     state_q <= ST_RUN;
                  end else begin
                     done_q <= 1'b1;
                  end
               end
            end
            ST_RUN: begin
               if (step) begin
                  if (last_chk) begin
                     chk_q <= '0;
                     if (last_lane) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                        rsp_q   <= (op_q == OP_GATHER);
                     end else begin
                        lane_q <= lane_q + 1'b1;
                     end
                  end else begin
                     chk_q <= chk_q + 1'b1;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R9: no memory request while a new command may be taken
   a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !cmd_ready);

   // R7: within one operation the lane index never moves backwards
   a_r7_lane_order: assert property (@(posedge clk) disable iff (!rst_n)
      (running && $past(running) && !$past(accept)) |-> (lane_q >= $past(lane_q)));

   // R3: chunk position stays inside the chosen chunk length
   a_r3_chunk_bound: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> (chk_q <= chunk_q));

endmodule

// File: rtl/sgl_lane_unit.sv
module sgl_lane_unit
   import sgl_pkg::*;
#(
   parameter int LANES     = 16,
   parameter int CHUNK_MAX = 8,
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 12,
   parameter int OFF_W     = 12,
   localparam int CHK_W    = $clog2(CHUNK_MAX),
   localparam int LANE_W   = $clog2(LANES),
   localparam int FLAT_W   = CHUNK_MAX * LANES * DATA_W
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cmd_valid,
   output logic                   cmd_ready,
   input  logic [1:0]             cmd_op,
   input  logic [ADDR_W-1:0]      cmd_base,
   input  logic [LANES*OFF_W-1:0] cmd_vec,
   input  logic [LANES-1:0]       cmd_mask,
   input  logic [CHK_W-1:0]       cmd_chunk,
   input  logic [FLAT_W-1:0]      cmd_wdata,
   output logic                   cmd_done,
   output logic                   rsp_valid,
   output logic [FLAT_W-1:0]      rsp_data,
   output logic                   mem_req,
   output logic                   mem_we,
   output logic [ADDR_W-1:0]      mem_addr,
   output logic [DATA_W-1:0]      mem_wdata,
   input  logic                   mem_ack,
   input  logic [DATA_W-1:0]      mem_rdata
);

   // elaboration-time parameter checks
   if (LANES < 2)                        $error("LANES must be at least 2");
   if (CHUNK_MAX < 2)                    $error("CHUNK_MAX must be at least 2");
   if ((1 << CHK_W) != CHUNK_MAX)        $error("CHUNK_MAX must be a power of two");
   if (OFF_W > ADDR_W)                   $error("OFF_W must not exceed ADDR_W");
   if (DATA_W < 1)                       $error("DATA_W must be positive");

   logic                   accept;
   logic [LANES*OFF_W-1:0] off_flat;
   logic [LANE_W-1:0]      cur_lane;
   logic [CHK_W-1:0]       cur_chk;
   logic                   rd_wr_en;
   sgl_op_e                op_in;

   assign op_in = sgl_op_e'(cmd_op);

   sgl_lane_offsets #(
      .LANES (LANES),
      .OFF_W (OFF_W)
   ) i_offsets (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_en   (accept && op_in == OP_SET),
      .shift_en (accept && op_in == OP_SHIFT),
      .vec_in   (cmd_vec),
      .off_flat (off_flat)
   );

   sgl_sequencer #(
      .LANES     (LANES),
      .CHUNK_MAX (CHUNK_MAX),
      .ADDR_W    (ADDR_W),
      .OFF_W     (OFF_W)
   ) i_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_op    (cmd_op),
      .cmd_base  (cmd_base),
      .cmd_mask  (cmd_mask),
      .cmd_chunk (cmd_chunk),
      .off_flat  (off_flat),
      .cmd_ready (cmd_ready),
      .accept    (accept),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_ack   (mem_ack),
      .cur_lane  (cur_lane),
      .cur_chk   (cur_chk),
      .rd_wr_en  (rd_wr_en),
      .cmd_done  (cmd_done),
      .rsp_valid (rsp_valid)
   );

   // one buffer: cleared for a gather, filled from cmd_wdata for a scatter
   sgl_data_buf #(
      .LANES     (LANES),
      .CHUNK_MAX (CHUNK_MAX),
      .DATA_W    (DATA_W)
   ) i_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (accept && op_in == OP_GATHER),
      .load      (accept && op_in == OP_SCATTER),
      .load_data (cmd_wdata),
      .wr_en     (rd_wr_en),
      .wr_lane   (cur_lane),
      .wr_chk    (cur_chk),
      .wr_data   (mem_rdata),
      .rd_lane   (cur_lane),
      .rd_chk    (cur_chk),
      .rd_data   (mem_wdata),
      .buf_flat  (rsp_data)
   );

   // R10: a pending request holds still until acknowledged
   a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                 && $stable(mem_wdata)));

   // R2: gather result is only presented with completion
   a_r2_rsp_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> cmd_done);

   // R9: completion returns the block to idle
   a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_done |-> cmd_ready);

endmodule

// File: tb/test_sgl_lane_unit.sv
module test_sgl_lane_unit;

   localparam int LANES = 16;
   localparam int CMAX  = 8;
   localparam int DW    = 32;
   localparam int AW    = 12;
   localparam int OW    = 12;
   localparam int CW    = 3;
   localparam int FW    = CMAX * LANES * DW;
   localparam int MSZ   = 1 << AW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;   // 50 MHz

   logic              cmd_valid = 1'b0;
   logic              cmd_ready;
   logic [1:0]        cmd_op = '0;
   logic [AW-1:0]     cmd_base = '0;
   logic [LANES*OW-1:0] cmd_vec = '0;
   logic [LANES-1:0]  cmd_mask = '0;
   logic [CW-1:0]     cmd_chunk = '0;
   logic [FW-1:0]     cmd_wdata = '0;
   logic              cmd_done;
   logic              rsp_valid;
   logic [FW-1:0]     rsp_data;
   logic              mem_req;
   logic              mem_we;
   logic [AW-1:0]     mem_addr;
   logic [DW-1:0]     mem_wdata;
   logic              mem_ack = 1'b0;
   logic [DW-1:0]     mem_rdata = '0;

   sgl_lane_unit #(
      .LANES(LANES), .CHUNK_MAX(CMAX), .DATA_W(DW), .ADDR_W(AW), .OFF_W(OW)
   ) i_sgl_lane_unit (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
      .cmd_base(cmd_base), .cmd_vec(cmd_vec), .cmd_mask(cmd_mask),
      .cmd_chunk(cmd_chunk), .cmd_wdata(cmd_wdata), .cmd_done(cmd_done),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   int n_chk = 0;
   int n_fail = 0;

   task automatic check(input bit ok, input string req, input string what);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s", req, what);
      end
   endtask

   // ---------------- memory model ----------------
   logic [DW-1:0] bmem [MSZ];
   logic [DW-1:0] emem [MSZ];
   logic [AW-1:0] log_addr [256];
   logic          log_we   [256];
   int            log_n = 0;
   int            hold_bad = 0;
   bit            pend = 0;
   logic [AW-1:0] pend_addr = '0;
   logic          pend_we = 1'b0;

   always @(negedge clk) begin
      bit a;
      if (pend && !(mem_req && mem_addr == pend_addr && mem_we == pend_we)) hold_bad++;
      a = mem_req && ($urandom_range(0, 3) != 0);
      mem_ack   = a;
      mem_rdata = bmem[mem_addr];
      pend      = mem_req && !a;
      pend_addr = mem_addr;
      pend_we   = mem_we;
   end

   always @(posedge clk) begin
      if (mem_req && mem_ack) begin
         if (mem_we) bmem[mem_addr] <= mem_wdata;
         if (log_n < 256) begin
            log_addr[log_n] <= mem_addr;
            log_we[log_n]   <= mem_we;
         end
         log_n <= log_n + 1;
      end
   end

   // ---------------- reference state ----------------
   logic [OW-1:0] off_m [LANES];
   logic [FW-1:0] exp_rsp;

   function automatic logic [AW-1:0] el_addr(input logic [AW-1:0] base, input int l, input int k);
      return base + AW'(off_m[l]) + AW'(k);
   endfunction

   // runs one command; returns after cmd_done (or timeout)
   task automatic run_cmd(input logic [1:0] op, input logic [AW-1:0] base,
                          input logic [LANES*OW-1:0] vec, input logic [LANES-1:0] mask,
                          input logic [CW-1:0] chunk, input logic [FW-1:0] wd,
                          output bit saw_rsp);
      int wd_cnt;
      @(negedge clk);
      while (!cmd_ready) @(negedge clk);
      log_n = 0;
      hold_bad = 0;
      cmd_op = op; cmd_base = base; cmd_vec = vec; cmd_mask = mask;
      cmd_chunk = chunk; cmd_wdata = wd; cmd_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
      wd_cnt = 0;
      while (!cmd_done && wd_cnt < 5000) begin
         @(negedge clk);
         wd_cnt++;
      end
      check(cmd_done, "R9", $sformatf("done actual=%0d expected=1", cmd_done));
      saw_rsp = rsp_valid;
   endtask

   task automatic do_set(input logic [LANES*OW-1:0] vec);
      bit r;
      run_cmd(2'b00, '0, vec, '0, '0, '0, r);
      for (int l = 0; l < LANES; l++) off_m[l] = vec[l*OW +: OW];
      check(log_n == 0 && !r, "R1", $sformatf("set accesses actual=%0d expected=0", log_n));
   endtask

   task automatic do_shift(input logic [LANES*OW-1:0] vec);
      bit r;
      run_cmd(2'b01, '0, vec, '0, '0, '0, r);
      for (int l = 0; l < LANES; l++) off_m[l] = off_m[l] + vec[l*OW +: OW];
      check(log_n == 0 && !r, "R8", $sformatf("shift accesses actual=%0d expected=0", log_n));
   endtask

   // checks access count, order and request hold for the last command
   task automatic check_trace(input logic [AW-1:0] base, input logic [LANES-1:0] mask,
                              input int chunk, input logic we);
      int n = 0;
      bit ok = 1;
      for (int l = 0; l < LANES; l++) begin
         if (mask[l]) begin
            for (int k = 0; k <= chunk; k++) begin
               if (n >= log_n || log_addr[n] != el_addr(base, l, k) || log_we[n] != we) ok = 0;
               n++;
            end
         end
      end
      check(ok && n == log_n, "R7",
            $sformatf("access trace count actual=%0d expected=%0d order_ok=%0d", log_n, n, ok));
      check(hold_bad == 0, "R10", $sformatf("hold breaks actual=%0d expected=0", hold_bad));
   endtask

   task automatic do_gather(input logic [AW-1:0] base, input logic [LANES-1:0] mask,
                            input int chunk);
      bit r;
      int bad = -1;
      exp_rsp = '0;
      for (int l = 0; l < LANES; l++)
         if (mask[l])
            for (int k = 0; k <= chunk; k++)
               exp_rsp[(k*LANES + l)*DW +: DW] = bmem[el_addr(base, l, k)];
      run_cmd(2'b10, base, '0, mask, CW'(chunk), '0, r);
      check(r, "R2", $sformatf("rsp_valid actual=%0d expected=1", r));
      for (int e = 0; e < CMAX*LANES; e++)
         if (bad < 0 && rsp_data[e*DW +: DW] != exp_rsp[e*DW +: DW]) bad = e;
      check(bad < 0, "R2", $sformatf("gather entry %0d actual=%h expected=%h", bad,
            (bad < 0) ? '0 : rsp_data[bad*DW +: DW], (bad < 0) ? '0 : exp_rsp[bad*DW +: DW]));
      check_trace(base, mask, chunk, 1'b0);
   endtask

   task automatic do_scatter(input logic [AW-1:0] base, input logic [LANES-1:0] mask,
                             input int chunk, input logic [FW-1:0] wd);
      bit r;
      int bad = -1;
      for (int a = 0; a < MSZ; a++) emem[a] = bmem[a];
      for (int l = 0; l < LANES; l++)
         if (mask[l])
            for (int k = 0; k <= chunk; k++)
               emem[el_addr(base, l, k)] = wd[(k*LANES + l)*DW +: DW];
      run_cmd(2'b11, base, '0, mask, CW'(chunk), wd, r);
      check(!r, "R5", $sformatf("rsp_valid on scatter actual=%0d expected=0", r));
      @(negedge clk);
      for (int a = 0; a < MSZ; a++)
         if (bad < 0 && bmem[a] != emem[a]) bad = a;
      check(bad < 0, "R5", $sformatf("memory word %0d actual=%h expected=%h", bad,
            (bad < 0) ? '0 : bmem[bad], (bad < 0) ? '0 : emem[bad]));
      check_trace(base, mask, chunk, 1'b1);
   endtask

   function automatic logic [FW-1:0] rand_data();
      logic [FW-1:0] v;
      for (int e = 0; e < CMAX*LANES; e++) v[e*DW +: DW] = $urandom();
      return v;
   endfunction

   function automatic logic [LANES*OW-1:0] rand_vec();
      logic [LANES*OW-1:0] v;
      for (int l = 0; l < LANES; l++) v[l*OW +: OW] = OW'($urandom());
      return v;
   endfunction

   // ---------------- watchdog ----------------
   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      n_chk++;
      $display("FAIL R9 watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   // ---------------- stimulus ----------------
   initial begin
      logic [LANES*OW-1:0] v;
      logic [FW-1:0]       wd;
      void'($urandom(32'd20240611));
      for (int a = 0; a < MSZ; a++) bmem[a] = (a * 32'h9E37_79B1) ^ 32'h5A5A_0000;
      for (int l = 0; l < LANES; l++) off_m[l] = '0;

      repeat (3) @(negedge clk);
      check(cmd_ready === 1'b1, "R9", $sformatf("reset ready actual=%b expected=1", cmd_ready));
      check(mem_req === 1'b0, "R10", $sformatf("reset req actual=%b expected=0", mem_req));
      check(cmd_done === 1'b0 && rsp_valid === 1'b0, "R9",
            $sformatf("reset done/rsp actual=%b%b expected=00", cmd_done, rsp_valid));
      rst_n = 1'b1;
      @(negedge clk);

      // R1 + R3: set offsets l*16, default single-element gather
      for (int l = 0; l < LANES; l++) v[l*OW +: OW] = OW'(l * 16);
      do_set(v);
      do_gather(12'd40, '1, 0);
      check(rsp_data[3*DW +: DW] == bmem[40 + 48], "R3",
            $sformatf("chunk1 lane3 actual=%h expected=%h", rsp_data[3*DW +: DW], bmem[88]));

      // R2 + R11: chunk of 4, layout [chunk][lane], upper positions zero
      do_gather(12'd200, '1, 3);
      check(rsp_data[(2*LANES + 5)*DW +: DW] == bmem[200 + 80 + 2], "R2",
            $sformatf("k2 lane5 actual=%h expected=%h", rsp_data[(2*LANES + 5)*DW +: DW], bmem[282]));
      check(rsp_data[FW-1 : 4*LANES*DW] == '0, "R11",
            $sformatf("upper chunks actual_nonzero=%0d expected=0", rsp_data[FW-1 : 4*LANES*DW] != '0));

      // R4: masked lane with an offset running off the region end
      v[5*OW +: OW] = 12'hFFD;
      do_set(v);
      do_gather(12'd0, 16'hFDDF, 7);
      begin
         bit z = 1;
         for (int k = 0; k < CMAX; k++) if (rsp_data[(k*LANES + 5)*DW +: DW] != '0) z = 0;
         check(z, "R4", $sformatf("masked lane5 zero actual=%0d expected=1", z));
      end

      // R6: overlapping scatter, offsets l*4, chunk 8, highest lane wins
      for (int l = 0; l < LANES; l++) v[l*OW +: OW] = OW'(l * 4);
      do_set(v);
      wd = rand_data();
      do_scatter(12'd100, '1, 7, wd);
      @(negedge clk);
      check(bmem[108] == wd[(0*LANES + 2)*DW +: DW], "R6",
            $sformatf("addr108 actual=%h expected=%h", bmem[108], wd[(2)*DW +: DW]));

      // R5: masked lane 15 keeps the tail of the region untouched
      wd = rand_data();
      do_scatter(12'd600, 16'h7FFF, 7, wd);
      @(negedge clk);
      check(bmem[600 + 67] != wd[(7*LANES + 15)*DW +: DW] || bmem[667] == emem[667], "R5",
            $sformatf("addr667 actual=%h expected=%h", bmem[667], emem[667]));

      // R8: per-lane shift then gather
      for (int l = 0; l < LANES; l++) v[l*OW +: OW] = OW'(l + 1);
      do_shift(v);
      do_gather(12'd100, '1, 1);
      check(rsp_data[(0*LANES + 3)*DW +: DW] == bmem[100 + 12 + 4], "R8",
            $sformatf("lane3 after shift actual=%h expected=%h",
                      rsp_data[3*DW +: DW], bmem[116]));

      // constrained random mix
      for (int t = 0; t < 30; t++) begin
         int kind = $urandom_range(0, 9);
         if (kind < 2) do_set(rand_vec());
         else if (kind < 3) do_shift(rand_vec());
         else if (kind < 6) do_gather(AW'($urandom()), LANES'($urandom()), $urandom_range(0, CMAX-1));
         else do_scatter(AW'($urandom()), LANES'($urandom()), $urandom_range(0, CMAX-1), rand_data());
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule